// File: doc/BRIEF.md
# Single-Step Rotate and Shift Unit with Flag Generation

This block moves an operand by exactly one bit position and produces a new condition-flag byte next to the result. A four-bit operation code picks the transform. There are two groups of operations, and each group updates the flags in its own way.

The first group is the fast accumulator rotates. They keep the sign, zero and parity/overflow flags from the incoming flag byte. The second group is the general rotates and shifts. They rebuild every flag from the result.

Operands and the incoming flags are sampled on each rising clock edge. The result and flags appear on registered outputs one cycle later. A caller running a sequence of single-bit moves feeds the returned flag byte back in, so the carry chains from one step to the next.

Top module: `rotshift_unit`

## Requirements
- R1: A synchronous active-high reset drives both the result and the flag outputs to zero.
- R2: Outputs are registered. The result and flags seen after a rising edge come from the inputs sampled at that edge, and they hold steady between edges.
- R3: Code 0 rotates left circularly and code 1 rotates right circularly (fast group). In each case the bit that leaves the word enters the opposite end and also becomes the carry, flag bit 0.
- R4: Code 2 rotates left through carry and code 3 rotates right through carry (fast group). The incoming carry, flag bit 0, fills the vacated end, and the bit that leaves becomes the new carry.
- R5: For codes 0 to 3, the sign (bit 7), zero (bit 6) and parity/overflow (bit 2) flags are copied from the incoming flag byte. Half-carry (bit 4) and subtract (bit 1) are cleared.
- R6: Code 4 rotates left circularly and code 5 rotates right circularly (general group). The wrapped bit also becomes the carry.
- R7: Code 6 rotates left through carry and code 7 rotates right through carry (general group), with the same carry behaviour as R4.
- R8: Code 9 shifts right arithmetically and keeps the top bit. Code 11 shifts right logically and inserts zero at the top. Both put the old bit 0 into the carry.
- R9: Code 8 shifts left and inserts zero. Code 10 shifts left and inserts one at bit 0. Both put the old top bit into the carry.
- R10: For codes 4 to 11, the flags are rebuilt from the result:
  - sign equals the result's top bit;
  - zero is set when the result is all zeros;
  - parity/overflow is set when the result has an even number of ones;
  - half-carry and subtract are cleared.
- R11: Codes 12 to 15 pass the operand and the flag byte through unchanged.
- R12: For codes 0 to 11, flag bits 5 and 3 equal result bits 5 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| val_i | input | DATA_W | Operand |
| flags_i | input | 8 | Incoming flag byte; bit 0 is the carry |
| res_o | output | DATA_W | Registered result |
| flags_o | output | 8 | Registered flag byte |

## Verification
The bench aims at the corners where the two groups of operations differ.

- It supplies a set incoming carry to the through-carry rotates. A design that confused them with the circular rotates would output the wrong end bit.
- It runs a fast rotate with incoming flags all set. A design that rebuilt the flags would lose the kept sign, zero and parity bits, and a design that forgot to clear half-carry and subtract would leave them set.
- It runs the two left shifts and the two right shifts on operands whose top and bottom bits differ. A swapped fill bit then shows up as a wrong result and a wrong parity.
- It checks that the unused codes leave both bytes unchanged.
- It checks zero results: the zero and parity flags must both rise.

// File: rtl/rotshift_pkg.sv
package rotshift_pkg;

  typedef enum logic [3:0] {
    OP_QROL  = 4'd0,
    OP_QROR  = 4'd1,
    OP_QRCL  = 4'd2,
    OP_QRCR  = 4'd3,
    OP_ROL   = 4'd4,
    OP_ROR   = 4'd5,
    OP_RCL   = 4'd6,
    OP_RCR   = 4'd7,
    OP_SHL0  = 4'd8,
    OP_SAR   = 4'd9,
    OP_SHL1  = 4'd10,
    OP_SHR   = 4'd11
  } rs_op_e;

  typedef enum logic [1:0] {
    FK_PASS = 2'd0,
    FK_FAST = 2'd1,
    FK_FULL = 2'd2
  } flag_kind_e;

  // flag byte bit positions
  localparam int FB_C  = 0;
  localparam int FB_N  = 1;
  localparam int FB_PV = 2;
  localparam int FB_X3 = 3;
  localparam int FB_H  = 4;
  localparam int FB_X5 = 5;
  localparam int FB_Z  = 6;
  localparam int FB_S  = 7;

  localparam logic [7:0] FAST_KEEP = (8'd1 << FB_S) | (8'd1 << FB_Z) | (8'd1 << FB_PV);

endpackage

// File: rtl/rotshift_core.sv
module rotshift_core
  import rotshift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o,
  output flag_kind_e        kind_o
);

  localparam int MSB = DATA_W - 1;

  logic go_left;
  logic fill;
  logic active;

  always_comb begin
    go_left = 1'b0;
    fill    = 1'b0;
    active  = 1'b1;
    kind_o  = FK_FULL;
    case (op_i)
      OP_QROL: begin go_left = 1'b1; fill = val_i[MSB]; kind_o = FK_FAST; end
      OP_QROR: begin go_left = 1'b0; fill = val_i[0];   kind_o = FK_FAST; end
      OP_QRCL: begin go_left = 1'b1; fill = cin_i;      kind_o = FK_FAST; end
      OP_QRCR: begin go_left = 1'b0; fill = cin_i;      kind_o = FK_FAST; end
      OP_ROL:  begin go_left = 1'b1; fill = val_i[MSB]; end
      OP_ROR:  begin go_left = 1'b0; fill = val_i[0];   end
      OP_RCL:  begin go_left = 1'b1; fill = cin_i;      end
      OP_RCR:  begin go_left = 1'b0; fill = cin_i;      end
      OP_SHL0: begin go_left = 1'b1; fill = 1'b0;       end
      OP_SAR:  begin go_left = 1'b0; fill = val_i[MSB]; end
      OP_SHL1: begin go_left = 1'b1; fill = 1'b1;       end
      OP_SHR:  begin go_left = 1'b0; fill = 1'b0;       end
      default: begin active = 1'b0; kind_o = FK_PASS;   end
    endcase
  end

  always_comb begin
    if (!active) begin
      res_o  = val_i;
      cout_o = cin_i;
    end else if (go_left) begin
      res_o  = {val_i[MSB-1:0], fill};
      cout_o = val_i[MSB];
    end else begin
      res_o  = {fill, val_i[MSB:1]};
      cout_o = val_i[0];
    end
  end

endmodule

// File: rtl/rotshift_flags.sv
module rotshift_flags
  import rotshift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  flag_kind_e        kind_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              cout_i,
  input  logic [7:0]        flags_i,
  output logic [7:0]        flags_o
);

  localparam int MSB = DATA_W - 1;

  logic [7:0] copied;
  logic [7:0] rebuilt;

  always_comb begin
    copied         = '0;
    copied[FB_X5]  = res_i[5];
    copied[FB_X3]  = res_i[3];
    copied[FB_C]   = cout_i;

    rebuilt        = copied;
    rebuilt[FB_S]  = res_i[MSB];
    rebuilt[FB_Z]  = ~|res_i;
    rebuilt[FB_PV] = ~^res_i;

    case (kind_i)
      FK_FAST: flags_o = (flags_i & FAST_KEEP) | copied;
      FK_FULL: flags_o = rebuilt;
      default: flags_o = flags_i;
    endcase
  end

endmodule

// File: rtl/rotshift_unit.sv
module rotshift_unit
  import rotshift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic [7:0]        flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic [7:0]        flags_o
);

  logic [DATA_W-1:0] res_d;
  logic              cout_d;
  flag_kind_e        kind_d;
  logic [7:0]        flags_d;

  rotshift_core #(.DATA_W(DATA_W)) u_core (
    .op_i   (op_i),
    .val_i  (val_i),
    .cin_i  (flags_i[FB_C]),
    .res_o  (res_d),
    .cout_o (cout_d),
    .kind_o (kind_d)
  );

  rotshift_flags #(.DATA_W(DATA_W)) u_flags (
    .kind_i  (kind_d),
    .res_i   (res_d),
    .cout_i  (cout_d),
    .flags_i (flags_i),
    .flags_o (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      flags_o <= '0;
    end else begin
      res_o   <= res_d;
      flags_o <= flags_d;
    end
  end

endmodule

// File: rtl/rotshift_unit_chk.sv
module rotshift_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] val_i,
  input logic [7:0]        flags_i,
  input logic [DATA_W-1:0] res_o,
  input logic [7:0]        flags_o
);

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res_o == '0 && flags_o == 8'h00));

  p_fast_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) < 4'd4)
      |-> ((flags_o & 8'hC4) == ($past(flags_i) & 8'hC4) && flags_o[4] == 1'b0 && flags_o[1] == 1'b0));

  p_full_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) >= 4'd4 && $past(op_i) < 4'd12)
      |-> (flags_o[6] == (res_o == '0) && flags_o[7] == res_o[DATA_W-1] && flags_o[2] == ~^res_o));

  p_pass_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) >= 4'd12)
      |-> (res_o == $past(val_i) && flags_o == $past(flags_i)));

  p_copy53_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) < 4'd12)
      |-> (flags_o[5] == res_o[5] && flags_o[3] == res_o[3]));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(op_i) && $stable(val_i) && $stable(flags_i) && $past(op_i) >= 4'd12)
      |=> $stable(res_o));

endmodule

bind rotshift_unit rotshift_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_i    (op_i),
  .val_i   (val_i),
  .flags_i (flags_i),
  .res_o   (res_o),
  .flags_o (flags_o)
);

// File: tb/tb_rotshift_unit.sv
module tb_rotshift_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_i = '0;
  logic [7:0] val_i = '0;
  logic [7:0] flags_i = '0;
  logic [7:0] res_o;
  logic [7:0] flags_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rotshift_unit #(.DATA_W(8)) dut (
    .clk(clk), .rst(rst), .op_i(op_i), .val_i(val_i),
    .flags_i(flags_i), .res_o(res_o), .flags_o(flags_o)
  );

  // {op, operand, flags in, expected result, expected flags}
  localparam int NV = 17;
  localparam logic [35:0] VEC [NV] = '{
    {4'd0,  8'h81, 8'h00, 8'h03, 8'h01},
    {4'd1,  8'h01, 8'hFF, 8'h80, 8'hC5},
    {4'd2,  8'h7F, 8'h01, 8'hFF, 8'h28},
    {4'd3,  8'h54, 8'hD6, 8'h2A, 8'hEC},
    {4'd4,  8'h80, 8'h00, 8'h01, 8'h01},
    {4'd5,  8'h11, 8'hFF, 8'h88, 8'h8D},
    {4'd6,  8'h80, 8'h00, 8'h00, 8'h45},
    {4'd7,  8'h01, 8'h01, 8'h80, 8'h81},
    {4'd8,  8'hFF, 8'h00, 8'hFE, 8'hA9},
    {4'd9,  8'h81, 8'h00, 8'hC0, 8'h85},
    {4'd10, 8'h00, 8'hFF, 8'h01, 8'h00},
    {4'd11, 8'h81, 8'h00, 8'h40, 8'h01},
    {4'd12, 8'h5A, 8'h93, 8'h5A, 8'h93},
    {4'd15, 8'hA5, 8'h3C, 8'hA5, 8'h3C},
    {4'd10, 8'h80, 8'h00, 8'h01, 8'h01},
    {4'd11, 8'h01, 8'h00, 8'h00, 8'h45},
    {4'd9,  8'h7E, 8'h00, 8'h3F, 8'h2C}
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:   return "R3/R5/R12";
      4'd2, 4'd3:   return "R4/R5/R12";
      4'd4, 4'd5:   return "R6/R10/R12";
      4'd6, 4'd7:   return "R7/R10/R12";
      4'd8, 4'd10:  return "R9/R10/R12";
      4'd9, 4'd11:  return "R8/R10/R12";
      default:      return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] r, input logic [7:0] f,
                       input logic [7:0] er, input logic [7:0] ef);
    n_chk++;
    if (r !== er || f !== ef) begin
      n_bad++;
      $display("FAIL %s: got res=%02h flags=%02h, expected res=%02h flags=%02h", tag, r, f, er, ef);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state with non-zero inputs present
    op_i = 4'd12; val_i = 8'hFF; flags_i = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 reset", res_o, flags_o, 8'h00, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op_i = VEC[i][35:32]; val_i = VEC[i][31:24]; flags_i = VEC[i][23:16];
      @(negedge clk);
      check(tag_of(VEC[i][35:32]), res_o, flags_o, VEC[i][15:8], VEC[i][7:0]);
    end

    // R2: output does not change before the next edge
    @(negedge clk);
    op_i = 4'd13; val_i = 8'h3C; flags_i = 8'h11;
    @(negedge clk);
    check("R2 settle", res_o, flags_o, 8'h3C, 8'h11);
    op_i = 4'd0; val_i = 8'h40; flags_i = 8'h00;
    #1;
    check("R2 hold before edge", res_o, flags_o, 8'h3C, 8'h11);
    @(negedge clk);
    check("R2/R3 after edge", res_o, flags_o, 8'h80, 8'h00);

    // R4 vs R3: through-carry with carry clear inserts zero
    op_i = 4'd3; val_i = 8'h01; flags_i = 8'hC4;
    @(negedge clk);
    check("R4 carry clear", res_o, flags_o, 8'h00, 8'hC5);

    // R11: code 14 passes
    op_i = 4'd14; val_i = 8'hE7; flags_i = 8'h52;
    @(negedge clk);
    check("R11 code14", res_o, flags_o, 8'hE7, 8'h52);

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", res_o, flags_o, 8'h00, 8'h00);
    rst = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule